// File: doc/BRIEF.md
# Snake-Order Reference Window for a Single-Cycle SAD Engine

This block holds the reference pixels for a full-search block matcher and decides their order. An N×N current block is held steady on an input port. A register window of N rows by N+1 columns holds reference pixels. Every cycle the N² absolute differences between the current block and the window's left N columns go to one combinational adder tree. The block walks the search range column by column. Down one column, up the next, and one column to the right between them. Because of this, each new candidate needs only one new row of N pixels from the outside memory.

At the end of a column the block makes one vertical fetch of N pixels into the spare column. In the following cycle the window shifts left and makes no fetch. After that cycle the first candidate of the next column is already in the registers. Each SAD leaves the block on a registered output together with its candidate coordinates. A one-cycle done pulse follows the final candidate. The search-range memory sits outside the block and answers a fetch combinationally. Choosing the minimum SAD is also left to a later stage.

Top module: `snake_sad_engine`

## Requirements
- R1: While reset is held and afterwards until a start, sad_valid, done and fetch_req stay low.
- R2: Each reported SAD equals the sum over r,c in 0..N-1 of |cur(r,c) − ref(x+c, y+r)|, where (x,y) are the reported coordinates. cur(r,c) is cur_blk[(r·N+c)·PIX_W +: PIX_W].
- R3: Candidates come out in snake order. Columns x run 0..SR_W-1. Within an even x, y rises from 0 to SR_H-1. Within an odd x, y falls from SR_H-1 to 0.
- R4: A start seen in idle begins a fill. In the N cycles after the start edge, the block issues row fetches at (0,0)…(0,N-1). The first SAD is valid N+1 cycles after the start edge.
- R5: Inside a column, SADs come on consecutive cycles. Between two columns there is exactly one cycle without a SAD, and fetch_req is low in the step cycle that causes it (the left shift).
- R6: Each scan step that is not last in its column makes one row fetch (fetch_vert=0, pixel k from (fetch_x+k, fetch_y)). Scanning down, that row is at y=cy+N; scanning up, at y=cy-1. The last step of each column except the final one makes one column fetch (fetch_vert=1, pixel k from (fetch_x, fetch_y+k)) at x=cx+N, y=cy. The final candidate makes no fetch.
- R7: done is high for exactly one cycle, the cycle after the last valid SAD.
- R8: A start that arrives while a search is running has no effect. The output sequence and fetches are unchanged.
- R9: The SAD output does not overflow: a block of zeros against a reference of all 255 gives N·N·255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a search (used only when idle) |
| cur_blk | input | N·N·PIX_W | Current block, row-major, pixel 0 in the low bits |
| fetch_req | output | 1 | Reference fetch in this cycle |
| fetch_vert | output | 1 | 0: horizontal row of N pixels, 1: vertical column of N pixels |
| fetch_x | output | FW | Fetch start column |
| fetch_y | output | FW | Fetch start row |
| fetch_data | input | N·PIX_W | Fetched pixels, same cycle, pixel k at bits k·PIX_W |
| sad_valid | output | 1 | SAD and coordinates valid |
| sad | output | SW | Sum of absolute differences |
| sad_x | output | XW | Candidate column |
| sad_y | output | YW | Candidate row |
| done | output | 1 | One-cycle pulse after the final candidate |

## Verification
At each column boundary, the last SAD of the column is computed in the same cycle as the vertical fetch that fills the spare column. A stale or early-shifted spare column would therefore corrupt the next column's first SAD, not the current one. Every search crosses two such boundaries. The bench compares the SAD, the coordinates and the fetch kind and address on every clock against a model that lists the expected event for each cycle. A second pairing is a start arriving in the middle of a scan. It is provoked in one run, and the run is judged by the unchanged sequence and by the absence of activity after done.

// File: rtl/snake_pkg.sv
package snake_pkg;
  // step codes: rows shift in from the bottom (DN), from the top (UP), spare column load, left shift
  typedef enum logic [2:0] {
    STEP_IDLE, STEP_FILL, STEP_DN_ROW, STEP_DN_COL,
    STEP_SHIFT, STEP_UP_ROW, STEP_UP_COL, STEP_FINISH
  } step_t;

  function automatic logic step_emits(input step_t s);
    return (s == STEP_DN_ROW) || (s == STEP_DN_COL) || (s == STEP_UP_ROW) ||
           (s == STEP_UP_COL) || (s == STEP_FINISH);
  endfunction

  function automatic logic step_fetches(input step_t s);
    return (s == STEP_FILL) || (s == STEP_DN_ROW) || (s == STEP_DN_COL) ||
           (s == STEP_UP_ROW) || (s == STEP_UP_COL);
  endfunction

  function automatic logic step_is_col(input step_t s);
    return (s == STEP_DN_COL) || (s == STEP_UP_COL);
  endfunction
endpackage

// File: rtl/snake_ctrl.sv
module snake_ctrl import snake_pkg::*; #(
  parameter int N    = 4,
  parameter int SR_W = 3,
  parameter int SR_H = 3,
  parameter int XW   = 2,
  parameter int YW   = 2,
  parameter int FW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output step_t         step,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy,
  output logic          fetch_req,
  output logic          fetch_vert,
  output logic [FW-1:0] fetch_x,
  output logic [FW-1:0] fetch_y
);
  localparam int CW = $clog2(N + 1);
  localparam logic [XW-1:0] LAST_X   = XW'(SR_W - 1);
  localparam logic [YW-1:0] LAST_Y   = YW'(SR_H - 1);
  localparam logic [CW-1:0] FILL_END = CW'(N - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_SCAN, PH_SHIFT} phase_t;

  phase_t        phase;
  logic          dir_up;
  logic [CW-1:0] fill_cnt;
  logic          col_end;

  assign col_end = dir_up ? (cy == '0) : (cy == LAST_Y);

  always_comb begin
    case (phase)
      PH_IDLE:  step = STEP_IDLE;
      PH_FILL:  step = STEP_FILL;
      PH_SHIFT: step = STEP_SHIFT;
      default: begin
        if (!col_end)          step = dir_up ? STEP_UP_ROW : STEP_DN_ROW;
        else if (cx == LAST_X) step = STEP_FINISH;
        else                   step = dir_up ? STEP_UP_COL : STEP_DN_COL;
      end
    endcase
  end

  always_comb begin
    fetch_x = '0;
    fetch_y = '0;
    case (step)
      STEP_FILL:   fetch_y = FW'(fill_cnt);
      STEP_DN_ROW: begin fetch_x = FW'(cx); fetch_y = FW'(cy) + FW'(N); end
      STEP_UP_ROW: begin fetch_x = FW'(cx); fetch_y = FW'(cy) - FW'(1); end
      STEP_DN_COL, STEP_UP_COL: begin fetch_x = FW'(cx) + FW'(N); fetch_y = FW'(cy); end
      default: ;
    endcase
  end

  assign fetch_req  = step_fetches(step);
  assign fetch_vert = step_is_col(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      dir_up   <= 1'b0;
      fill_cnt <= '0;
      cx       <= '0;
      cy       <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_FILL;
          fill_cnt <= '0;
          cx       <= '0;
          cy       <= '0;
          dir_up   <= 1'b0;
        end
        PH_FILL: begin
          if (fill_cnt == FILL_END) phase <= PH_SCAN;
          else                      fill_cnt <= fill_cnt + 1'b1;
        end
        PH_SHIFT: begin
          cx     <= cx + 1'b1;
          dir_up <= ~dir_up;
          phase  <= PH_SCAN;
        end
        default: begin
          case (step)
            STEP_DN_ROW: cy <= cy + 1'b1;
            STEP_UP_ROW: cy <= cy - 1'b1;
            STEP_DN_COL, STEP_UP_COL: phase <= PH_SHIFT;
            STEP_FINISH: phase <= PH_IDLE;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/snake_window.sv
module snake_window import snake_pkg::*; #(
  parameter int N     = 4,
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  step_t                  step,
  input  logic [N*PIX_W-1:0]     in_data,
  output logic [N*N*PIX_W-1:0]   cand
);
  logic [PIX_W-1:0] win [N][N+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c <= N; c++) win[r][c] <= '0;
    end else begin
      case (step)
        STEP_FILL, STEP_DN_ROW: begin
          for (int r = 0; r < N - 1; r++)
            for (int c = 0; c <= N; c++) win[r][c] <= win[r+1][c];
          for (int c = 0; c < N; c++) win[N-1][c] <= in_data[c*PIX_W +: PIX_W];
        end
        STEP_UP_ROW: begin
          for (int r = 1; r < N; r++)
            for (int c = 0; c <= N; c++) win[r][c] <= win[r-1][c];
          for (int c = 0; c < N; c++) win[0][c] <= in_data[c*PIX_W +: PIX_W];
        end
        STEP_DN_COL, STEP_UP_COL: begin
          for (int r = 0; r < N; r++) win[r][N] <= in_data[r*PIX_W +: PIX_W];
        end
        STEP_SHIFT: begin
          for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) win[r][c] <= win[r][c+1];
        end
        default: ;
      endcase
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign cand[(r*N+c)*PIX_W +: PIX_W] = win[r][c];
    end
  end
endmodule

// File: rtl/snake_sad_tree.sv
module snake_sad_tree #(
  parameter int N     = 4,
  parameter int PIX_W = 8,
  parameter int SW    = 12
) (
  input  logic [N*N*PIX_W-1:0] cur,
  input  logic [N*N*PIX_W-1:0] cand,
  output logic [SW-1:0]        sad
);
  localparam int NL = N * N;
  localparam int LV = $clog2(NL);
  localparam int P  = 1 << LV;

  function automatic logic [PIX_W-1:0] absdiff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  logic [SW-1:0] node [2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < NL) begin : g_pix
      assign node[P-1+i] = SW'(absdiff(cur[i*PIX_W +: PIX_W], cand[i*PIX_W +: PIX_W]));
    end else begin : g_pad
      assign node[P-1+i] = '0;
    end
  end

  for (genvar i = 0; i < P - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sad = node[0];
endmodule

// File: rtl/snake_sad_engine.sv
module snake_sad_engine import snake_pkg::*; #(
  parameter int N     = 4,
  parameter int SR_W  = 3,
  parameter int SR_H  = 3,
  parameter int PIX_W = 8,
  localparam int XW   = (SR_W > 1) ? $clog2(SR_W) : 1,
  localparam int YW   = (SR_H > 1) ? $clog2(SR_H) : 1,
  localparam int FW   = $clog2(SR_W + SR_H + 2*N),
  localparam int SW   = PIX_W + $clog2(N*N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [N*N*PIX_W-1:0] cur_blk,
  output logic                 fetch_req,
  output logic                 fetch_vert,
  output logic [FW-1:0]        fetch_x,
  output logic [FW-1:0]        fetch_y,
  input  logic [N*PIX_W-1:0]   fetch_data,
  output logic                 sad_valid,
  output logic [SW-1:0]        sad,
  output logic [XW-1:0]        sad_x,
  output logic [YW-1:0]        sad_y,
  output logic                 done
);
  step_t                 step_w;
  logic [XW-1:0]         cx_w;
  logic [YW-1:0]         cy_w;
  logic [N*N*PIX_W-1:0]  cand_w;
  logic [SW-1:0]         sad_w;
  logic                  fin_q;

  snake_ctrl #(.N(N), .SR_W(SR_W), .SR_H(SR_H), .XW(XW), .YW(YW), .FW(FW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .step(step_w), .cx(cx_w), .cy(cy_w),
    .fetch_req(fetch_req), .fetch_vert(fetch_vert), .fetch_x(fetch_x), .fetch_y(fetch_y)
  );

  snake_window #(.N(N), .PIX_W(PIX_W)) u_win (
    .clk(clk), .rst(rst), .step(step_w), .in_data(fetch_data), .cand(cand_w)
  );

  snake_sad_tree #(.N(N), .PIX_W(PIX_W), .SW(SW)) u_tree (
    .cur(cur_blk), .cand(cand_w), .sad(sad_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sad_valid <= 1'b0;
      sad       <= '0;
      sad_x     <= '0;
      sad_y     <= '0;
      fin_q     <= 1'b0;
      done      <= 1'b0;
    end else begin
      sad_valid <= step_emits(step_w);
      if (step_emits(step_w)) begin
        sad   <= sad_w;
        sad_x <= cx_w;
        sad_y <= cy_w;
      end
      fin_q <= (step_w == STEP_FINISH);
      done  <= fin_q;
    end
  end
endmodule

// File: rtl/snake_sad_checker.sv
module snake_sad_checker import snake_pkg::*; #(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input logic          clk,
  input logic          rst,
  input step_t         step,
  input logic          fetch_req,
  input logic          fetch_vert,
  input logic          sad_valid,
  input logic [XW-1:0] sad_x,
  input logic [YW-1:0] sad_y,
  input logic          done
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sad_valid && !done && !fetch_req));

  assert_no_fetch_in_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_SHIFT) |-> !fetch_req);

  assert_gap_after_shift_R5: assert property (@(posedge clk) disable iff (rst)
    $past(step == STEP_SHIFT) |-> !sad_valid);

  assert_down_column_R3: assert property (@(posedge clk) disable iff (rst)
    (sad_valid && $past(sad_valid) && (sad_x == $past(sad_x)) && !sad_x[0])
      |-> (sad_y == $past(sad_y) + 1'b1));

  assert_up_column_R3: assert property (@(posedge clk) disable iff (rst)
    (sad_valid && $past(sad_valid) && (sad_x == $past(sad_x)) && sad_x[0])
      |-> (sad_y == $past(sad_y) - 1'b1));

  assert_next_column_R3: assert property (@(posedge clk) disable iff (rst)
    (sad_valid && !$past(sad_valid) && $past(sad_valid, 2))
      |-> (sad_x == $past(sad_x, 2) + 1'b1));

  assert_col_fetch_then_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_vert) |=> (step == STEP_SHIFT));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(sad_valid) && !sad_valid));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind snake_sad_engine snake_sad_checker #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst(rst), .step(step_w), .fetch_req(fetch_req), .fetch_vert(fetch_vert),
  .sad_valid(sad_valid), .sad_x(sad_x), .sad_y(sad_y), .done(done)
);

// File: tb/sim_snake_sad_engine.sv
`timescale 1ns/1ps
module sim_snake_sad_engine;
  localparam int N = 4, SR_W = 3, SR_H = 3, PIX_W = 8;
  localparam int XW = 2, YW = 2, FW = $clog2(SR_W + SR_H + 2*N), SW = PIX_W + $clog2(N*N);
  localparam int K_LAST = N + 1 + (SR_W-1)*(SR_H+1) + SR_H - 1;
  localparam int K_FIN  = K_LAST - 1;

  logic clk = 0, rst = 1, start = 0;
  logic [N*N*PIX_W-1:0] cur_blk = '0;
  logic fetch_req, fetch_vert, sad_valid, done;
  logic [FW-1:0] fetch_x, fetch_y;
  logic [N*PIX_W-1:0] fetch_data;
  logic [SW-1:0] sad;
  logic [XW-1:0] sad_x;
  logic [YW-1:0] sad_y;

  int compared = 0, mismatched = 0;
  int seed = 0, mode = 0;

  always #5 clk = ~clk;

  snake_sad_engine #(.N(N), .SR_W(SR_W), .SR_H(SR_H), .PIX_W(PIX_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .cur_blk(cur_blk), .fetch_req(fetch_req),
    .fetch_vert(fetch_vert), .fetch_x(fetch_x), .fetch_y(fetch_y), .fetch_data(fetch_data),
    .sad_valid(sad_valid), .sad(sad), .sad_x(sad_x), .sad_y(sad_y), .done(done)
  );

  function automatic int refpix(input int md, input int sd, input int x, input int y);
    if (md == 1) return 255;
    return (x*29 + y*53 + x*y*7 + sd*13) % 256;
  endfunction

  always_comb begin
    for (int k = 0; k < N; k++)
      fetch_data[k*PIX_W +: PIX_W] = fetch_vert ?
        PIX_W'(refpix(mode, seed, int'(fetch_x), int'(fetch_y) + k)) :
        PIX_W'(refpix(mode, seed, int'(fetch_x) + k, int'(fetch_y)));
  end

  function automatic int curpix(input int r, input int c);
    return int'(cur_blk[(r*N+c)*PIX_W +: PIX_W]);
  endfunction

  function automatic int model_sad(input int x, input int y);
    int s = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int d = curpix(r, c) - refpix(mode, seed, x + c, y + r);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one search; kick_k >= 0 re-pulses start at that cycle index while busy
  task automatic run_search(input string sad_req, input int kick_k);
    int valids = 0;
    start = 1;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k <= K_LAST + 3; k++) begin
      bit ev = 0, ef = 0, evert = 0;
      int ex = 0, ey = 0, fx = 0, fy = 0;
      // expected SAD output at this sample
      if (k >= N + 1 && k <= K_LAST) begin
        int o = k - N - 1;
        int c = o / (SR_H + 1);
        int i = o % (SR_H + 1);
        if (i != SR_H) begin
          ev = 1; ex = c; ey = (c % 2 == 0) ? i : SR_H - 1 - i;
        end
      end
      // expected fetch in this step cycle
      if (k < N) begin
        ef = 1; fx = 0; fy = k;
      end else if (k < K_FIN) begin
        int o = k - N;
        int c = o / (SR_H + 1);
        int i = o % (SR_H + 1);
        if (i == SR_H - 1) begin
          ef = 1; evert = 1; fx = c + N; fy = (c % 2 == 0) ? SR_H - 1 : 0;
        end else if (i != SR_H) begin
          ef = 1; fx = c;
          fy = (c % 2 == 0) ? i + N : SR_H - 1 - i - 1;
        end
      end
      chk((k <= N) ? "R4" : "R5", "sad_valid", int'(sad_valid), int'(ev));
      if (ev && sad_valid) begin
        valids++;
        chk(sad_req, "sad", int'(sad), model_sad(ex, ey));
        chk("R3", "sad_x", int'(sad_x), ex);
        chk("R3", "sad_y", int'(sad_y), ey);
      end
      chk("R7", "done", int'(done), int'(k == K_LAST + 1));
      chk((k < N) ? "R4" : "R5", "fetch_req", int'(fetch_req), int'(ef));
      if (ef && fetch_req) begin
        chk("R6", "fetch_vert", int'(fetch_vert), int'(evert));
        chk((k < N) ? "R4" : "R6", "fetch_x", int'(fetch_x), fx);
        chk((k < N) ? "R4" : "R6", "fetch_y", int'(fetch_y), fy);
      end
      start = (k == kick_k) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    chk((kick_k >= 0) ? "R8" : "R3", "candidate count", valids, SR_W*SR_H);
    if (kick_k >= 0) begin
      for (int q = 0; q < 3; q++) begin
        chk("R8", "idle after late start", int'(fetch_req || sad_valid), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "sad_valid in reset", int'(sad_valid), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "sad_valid idle", int'(sad_valid), 0);
      chk("R1", "fetch_req idle", int'(fetch_req), 0);
      chk("R1", "done idle", int'(done), 0);
    end

    // pattern 1: ramp current block against formula reference
    for (int i = 0; i < N*N; i++) cur_blk[i*PIX_W +: PIX_W] = PIX_W'(i * 11 + 3);
    seed = 0; mode = 0;
    run_search("R2", -1);
    repeat (2) @(negedge clk);

    // pattern 2: current block copied from candidate (1,2) -> a zero SAD appears
    seed = 5;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        cur_blk[(r*N+c)*PIX_W +: PIX_W] = PIX_W'(refpix(0, 5, 1 + c, 2 + r));
    chk("R2", "model zero at match", model_sad(1, 2), 0);
    run_search("R2", 7);
    repeat (2) @(negedge clk);

    // pattern 3: extreme values, zero block against all-255 reference
    cur_blk = '0; mode = 1;
    chk("R9", "model max", model_sad(0, 0), N*N*255);
    run_search("R9", -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule